// File: doc/BRIEF.md
# Bit-Plane Weighted Stationary-Sample Correlator

This block holds eight sample values in fixed storage cells and correlates them against a programmable set of tap weights. Samples never move. A write pointer walks through the cells, starting at cell 0 and wrapping after the last cell. Each write puts the incoming sample into the cell under the pointer. The sample stays in that cell until the pointer comes round to it again.

The weights are stored as four one-bit planes, each eight bits wide, with one bit per cell. On every period strobe each plane rotates by one cell, so the weight pattern travels past the stationary samples. For each plane the block adds up the samples whose weight bit is 1. The four plane sums are then combined with gains 1, 2, 4 and 8, which gives each cell a weight from 0 to 15. The combined value is registered once per period. A plane can be reloaded at any time through its load strobe and the shared weight word. Used as a matched filter, the block loads one stored word and one weight pattern, then steps the period strobe.

Top module: `bitplane_correlator`

## Requirements
- R1: After reset, all cells and all weight planes hold zero, and `corr_out` is 0. A step taken after reset with no writes yields 0, whatever planes are loaded.
- R2: Each cycle with `wr_en` high stores `wr_data` in the cell under the pointer, then advances the pointer. The first write after reset goes to cell 0, and the write after cell 7 goes back to cell 0.
- R3: A cell keeps its value until the pointer writes that cell again. The other cells are not disturbed by writes.
- R4: When `plane_load[p]` is high, plane p takes `plane_word` in that cycle. Bit k of the word is the weight of cell k. A load takes priority over rotation for that plane.
- R5: On a cycle with `step` high, every plane that is not being loaded rotates: new bit k = old bit k-1 for k = 1 to 7, and new bit 0 = old bit 7.
- R6: On a step cycle, `corr_out` becomes the sum over cells k of sample_k × (8·b3_k + 4·b2_k + 2·b1_k + b0_k). Here bp_k is bit k of plane p. The sum uses the cells and planes as they stand after that cycle's write, load and rotation, and it appears one clock edge later.
- R7: On cycles with `step` low, `corr_out` holds its value.
- R8: The largest result, every cell at 255 and every weight at 15 (30600), is produced exactly, with no overflow of the 15-bit output.
- R9: With the stored word 0 1 1 1 0 0 1 0 (cells 0..7, sample value 1 for each one bit) and plane 0 aligned to the same pattern, the output reaches its peak of 4 at zero shift. Shifts on either side give smaller values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe: store sample and advance pointer |
| wr_data | input | 8 | Sample value |
| step | input | 1 | Period strobe: rotate planes and register result |
| plane_load | input | 4 | Per-plane load strobe, bit p loads plane p |
| plane_word | input | 8 | Weight word for loaded planes, bit k = cell k |
| corr_out | output | 15 | Registered correlation result |

## Verification
The bench looks for pointer wrap errors: a ninth write that misses cell 0 would leave a stale sample in the sum. It also checks the timing of write and load against step. A design that sums the old cells or unrotated planes would give a result lagging by one period. Rotation direction is covered by an asymmetric matched-filter pattern, which a reversed ring would mis-align. The full-scale case would show truncation if the accumulator were too narrow.

// File: rtl/corr_pkg.sv
`timescale 1ns/1ps
package corr_pkg;
  localparam int CELL_COUNT = 8;
  localparam int SAMPLE_BITS = 8;
  localparam int PLANE_COUNT = 4;
endpackage

// File: rtl/sample_bank.sv
`timescale 1ns/1ps
module sample_bank #(
  parameter int N = corr_pkg::CELL_COUNT,
  parameter int W = corr_pkg::SAMPLE_BITS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [W-1:0]        wr_data,
  output logic [N-1:0][W-1:0] cells
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam logic [PW-1:0] LAST = PW'(N - 1);

  logic [PW-1:0]        ptr_q, ptr_d;
  logic [N-1:0][W-1:0]  cells_q, cells_d;

  always_comb begin
    ptr_d   = ptr_q;
    cells_d = cells_q;
    if (wr_en) begin
      cells_d[ptr_q] = wr_data;
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      cells_q <= '0;
    end else begin
      ptr_q   <= ptr_d;
      cells_q <= cells_d;
    end
  end

  assign cells = cells_q;

  // R2
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr_q == LAST) |=> (ptr_q == '0));
  // R3
  cells_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cells_q));
endmodule

// File: rtl/weight_ring.sv
`timescale 1ns/1ps
module weight_ring #(
  parameter int N = corr_pkg::CELL_COUNT,
  parameter int P = corr_pkg::PLANE_COUNT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic [P-1:0]        load,
  input  logic [N-1:0]        word,
  output logic [P-1:0][N-1:0] planes
);
  logic [P-1:0][N-1:0] ring_q, ring_d;

  for (genvar p = 0; p < P; p++) begin : g_plane
    always_comb begin
      if (load[p])
        ring_d[p] = word;
      else if (step)
        ring_d[p] = {ring_q[p][N-2:0], ring_q[p][N-1]};
      else
        ring_d[p] = ring_q[p];
    end

    // R5
    rot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load[p]) |=> (ring_q[p][0] == $past(ring_q[p][N-1])));
    // R5
    rot_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!load[p]) |=> ($countones(ring_q[p]) == $countones($past(ring_q[p]))));
    // R4
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load[p] |=> (ring_q[p] == $past(word)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= '0;
    else        ring_q <= ring_d;
  end

  assign planes = ring_q;
endmodule

// File: rtl/plane_sum.sv
`timescale 1ns/1ps
module plane_sum #(
  parameter int N  = corr_pkg::CELL_COUNT,
  parameter int W  = corr_pkg::SAMPLE_BITS,
  parameter int P  = corr_pkg::PLANE_COUNT,
  parameter int RW = W + $clog2(N) + P
) (
  input  logic [N-1:0][W-1:0] cells,
  input  logic [P-1:0][N-1:0] planes,
  output logic [RW-1:0]       total
);
  logic [P-1:0][RW-1:0] part;

  for (genvar p = 0; p < P; p++) begin : g_part
    always_comb begin
      part[p] = '0;
      for (int k = 0; k < N; k++)
        if (planes[p][k]) part[p] = part[p] + RW'(cells[k]);
    end
  end

  always_comb begin
    total = '0;
    for (int p = 0; p < P; p++)
      total = total + (part[p] << p);
  end
endmodule

// File: rtl/bitplane_correlator.sv
`timescale 1ns/1ps
module bitplane_correlator #(
  parameter int N = corr_pkg::CELL_COUNT,
  parameter int W = corr_pkg::SAMPLE_BITS,
  parameter int P = corr_pkg::PLANE_COUNT
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       step,
  input  logic [P-1:0]               plane_load,
  input  logic [N-1:0]               plane_word,
  output logic [W+$clog2(N)+P-1:0]   corr_out
);
  localparam int RW = W + $clog2(N) + P;
  localparam longint MAX_RES = longint'(N) * ((64'd1 << W) - 1) * ((64'd1 << P) - 1);

  logic [N-1:0][W-1:0] cells_nx;
  logic [P-1:0][N-1:0] planes_nx;
  logic [N-1:0][W-1:0] cells_q;
  logic [P-1:0][N-1:0] planes_q;
  logic [RW-1:0]       sum_nx;
  logic [RW-1:0]       res_q, res_d;

  sample_bank #(.N(N), .W(W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .cells(cells_q)
  );

  weight_ring #(.N(N), .P(P)) u_ring (
    .clk(clk), .rst_n(rst_n), .step(step), .load(plane_load),
    .word(plane_word), .planes(planes_q)
  );

  // Next-state view: this cycle's write, load and rotation applied before summing
  logic [$clog2(N)-1:0] wp_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wp_q <= '0;
    else if (wr_en) wp_q <= (wp_q == ($clog2(N))'(N - 1)) ? '0 : wp_q + 1'b1;
  end

  always_comb begin
    cells_nx = cells_q;
    if (wr_en) cells_nx[wp_q] = wr_data;
    for (int p = 0; p < P; p++) begin
      if (plane_load[p])
        planes_nx[p] = plane_word;
      else
        planes_nx[p] = {planes_q[p][N-2:0], planes_q[p][N-1]};
    end
  end

  plane_sum #(.N(N), .W(W), .P(P), .RW(RW)) u_sum (
    .cells(cells_nx), .planes(planes_nx), .total(sum_nx)
  );

  always_comb begin
    res_d = res_q;
    if (step) res_d = sum_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= '0;
    else        res_q <= res_d;
  end

  assign corr_out = res_q;

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(corr_out));
  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    longint'(corr_out) <= MAX_RES);
  // R6
  zero_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && plane_load == '1 && plane_word == '0) |=> (corr_out == '0));
endmodule

// File: tb/tb_bitplane_correlator.sv
`timescale 1ns/1ps
module tb_bitplane_correlator;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic        step;
  logic [3:0]  plane_load;
  logic [7:0]  plane_word;
  logic [14:0] corr_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int       m_cell [8];
  bit [7:0] m_plane [4];
  int       m_ptr;
  int       m_res;

  always #10 clk = ~clk;

  bitplane_correlator dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .step(step),
    .plane_load(plane_load), .plane_word(plane_word), .corr_out(corr_out)
  );

  function automatic int model_sum();
    int s = 0;
    for (int k = 0; k < 8; k++)
      for (int p = 0; p < 4; p++)
        if (m_plane[p][k]) s += m_cell[k] << p;
    return s;
  endfunction

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  // Called at a negedge; leaves the bench at the following negedge
  task automatic cyc(bit w, int d, bit st, bit [3:0] ld, bit [7:0] word);
    wr_en = w; wr_data = 8'(d); step = st; plane_load = ld; plane_word = word;
    if (w) begin m_cell[m_ptr] = d & 255; m_ptr = (m_ptr + 1) % 8; end
    for (int p = 0; p < 4; p++) begin
      if (ld[p]) m_plane[p] = word;
      else if (st) m_plane[p] = {m_plane[p][6:0], m_plane[p][7]};
    end
    if (st) m_res = model_sum();
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; step = 0; plane_load = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 0; wr_en = 0; wr_data = 0; step = 0; plane_load = 0; plane_word = 0;
    for (int k = 0; k < 8; k++) m_cell[k] = 0;
    for (int p = 0; p < 4; p++) m_plane[p] = 0;
    m_ptr = 0; m_res = 0;
    repeat (3) @(negedge clk);
    check("R1 reset output", int'(corr_out), 0);
    rst_n = 1;
    @(negedge clk);
    // R1: all planes full, no writes -> cells still zero
    cyc(0, 0, 1, 4'hF, 8'hFF);
    check("R1 empty cells", int'(corr_out), 0);

    // R8: full scale
    for (int k = 0; k < 8; k++) cyc(1, 255, 0, 0, 0);
    cyc(0, 0, 1, 4'hF, 8'hFF);
    check("R8 full scale", int'(corr_out), 30600);

    // R7: writes and loads without step hold output
    cyc(1, 3, 0, 4'h2, 8'h0F);
    cyc(1, 77, 0, 0, 0);
    check("R7 hold", int'(corr_out), 30600);

    // R2/R3: reset-free refill; pointer now at 2, write 8 distinct, check wrap
    for (int k = 0; k < 8; k++) cyc(1, 10 + k, 0, 0, 0);
    // ptr back at 2: cell 2 holds 10, cell 1 holds 17
    cyc(0, 0, 1, 4'hF, 8'h04);
    check("R2 pointer wrap cell2", int'(corr_out), 15 * 10);
    cyc(0, 0, 1, 4'hF, 8'h02);
    check("R3 retention cell1", int'(corr_out), 15 * 17);
    check("R2 model agree", int'(corr_out), m_res);

    // R4: load beats rotation, per-plane weights
    cyc(0, 0, 1, 4'h1, 8'h01);
    check("R4 load priority", int'(corr_out), m_res);
    // R5: rotate only, plane0 bit moves 0 -> 1
    cyc(0, 0, 1, 4'h0, 8'h00);
    check("R5 rotation", int'(corr_out), m_res);

    // R9: matched filter 0 1 1 1 0 0 1 0 in cells 0..7
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    for (int k = 0; k < 8; k++) m_cell[k] = 0;
    for (int p = 0; p < 4; p++) m_plane[p] = 0;
    m_ptr = 0; m_res = 0;
    begin
      bit [7:0] pat = 8'b0100_1110; // bit k = cell k
      int peak = 0;
      for (int k = 0; k < 8; k++) cyc(1, int'(pat[k]), 0, 0, 0);
      cyc(0, 0, 1, 4'h1, pat);
      check("R9 zero shift", int'(corr_out), 4);
      for (int s = 1; s < 8; s++) begin
        cyc(0, 0, 1, 0, 0);
        check("R9 shifted", int'(corr_out), m_res);
        if (int'(corr_out) > peak) peak = int'(corr_out);
      end
      check("R9 off-peak below 4", int'(peak < 4), 1);
    end

    // R6: constrained random
    for (int i = 0; i < 400; i++) begin
      bit w = ($urandom % 3) != 0;
      bit st = ($urandom % 2) != 0;
      bit [3:0] ld = (($urandom % 4) == 0) ? 4'($urandom) : 4'h0;
      cyc(w, int'($urandom % 256), st, ld, 8'($urandom));
      check(st ? "R6 random step" : "R7 random hold", int'(corr_out), m_res);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule